// File: doc/BRIEF.md
# Hashed Address Table Learning Engine

This block owns a forwarding address table of 2048 entries, each 64 bits wide, held in an internal synchronous RAM. An 8-bit hash selects a bucket of consecutive slots. Each request is served by a state machine that walks the slots of that bucket one at a time. There are four request types. A lookup returns the forwarding port stored for a MAC address. A static insert writes an entry that carries a port mask and a priority. A dynamic learn writes an entry that carries a source port and the current timestamp. A clear invalidates every entry in the table.

All requests share one two-word packing, which is the record format of a hardware learning queue. Hash computation and frame forwarding are done outside this block. When a learn finds its bucket full, the engine evicts the slot whose stored timestamp lags the current time the most. The engine keeps a count of occupied entries and a count of bucket overflows.

States:
- `S_CLEAR` is entered from reset or from a clear request. It writes one zero entry per cycle.
- `S_IDLE` accepts a request.
- `S_READ` presents a slot address to the RAM.
- `S_EVAL` decides on the slot that was read back.
- `S_WRITE` stores the new entry.
- `S_DONE` pulses the response.

Transitions:
- IDLE→CLEAR on a clear request.
- IDLE→READ on any other request.
- READ→EVAL always.
- EVAL→READ when the slot is occupied by a different address and it is not the last slot.
- EVAL→WRITE for an insert or learn that finds a target slot.
- EVAL→DONE for a lookup, or for a static insert into a full bucket.
- WRITE→DONE always.
- CLEAR→DONE after the last entry of a requested clear.
- CLEAR→IDLE after the last entry of the reset-time clear.
- DONE→IDLE always.

Top module: `addr_learn_engine`

## Requirements
- R1: After reset, and after a clear request (`req_op`=3), every entry is invalid and `occupied` is 0. A clear keeps `req_ready` low while it writes one entry per cycle.
- R2: A request's word 0 is the low MAC word (MAC bytes 3,2,1,0, most significant first). In word 1, bits 15:0 hold MAC byte 5 above byte 4, bits 23:16 hold the hash, and bits 27:24 hold the port (learn source port or static port mask). The hash selects the 8 slots starting at index hash×8.
- R3: A lookup (`req_op`=0) returns stored bits 21:18 on `rsp_port` only when the matching entry has valid (bit 16) set and type (bit 17) clear. In every other case it returns `FWD_INIT` (default 15).
- R4: Two addresses match only when the low words are equal and high bits 15:0 are equal.
- R5: A static insert (`req_op`=1) writes type 1, the mask in bits 21:18 and the priority in bits 24:22. It overwrites a matching entry whether that entry is dynamic or static.
- R6: A learn (`req_op`=2) writes type 0, the port in bits 21:18 and `cur_time` in bits 31:22. A matching entry is updated in place.
- R7: Slots are scanned in index order. An invalid slot ends the scan: an insert or learn fills that slot and `occupied` grows by 1. An in-place update leaves `occupied` unchanged.
- R8: A learn into a full bucket with no match replaces the slot with the largest (cur_time − stored time) mod 2^TS_W. Ties go to the lowest index. `overflows` grows by 1 and `occupied` is unchanged.
- R9: A static insert into a full bucket with no match reports `rsp_err`=1 and leaves the table unchanged.
- R10: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low until exactly one single-cycle `rsp_valid` pulse ends the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Engine idle, request may be taken |
| req_op | input | 2 | 0 lookup, 1 static insert, 2 learn, 3 clear |
| req_w0 | input | 32 | Low MAC word |
| req_w1 | input | 32 | MAC high bits, hash, port |
| req_prio | input | 3 | Static entry priority |
| cur_time | input | TS_W | Current timestamp |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | No space for static insert |
| rsp_port | output | 4 | Lookup result |
| occupied | output | $clog2(ENTRY_CNT)+1 | Occupied entry count |
| overflows | output | CNT_W | Learn eviction count |

## Verification
The bench targets the following corner cases:
- Eviction where the oldest timestamp has wrapped past zero. A design that compared raw timestamps would evict the wrong slot.
- A bucket whose ages are all equal. Here the lowest slot must be replaced, not the last one examined.
- A static entry written over a dynamic one. This must hide the port from lookups; a design that ignored the type bit would keep forwarding.
- Keys that differ only in the high MAC bits. These catch a match that checks the low word alone.
- A static insert into a full bucket. This must fail without overwriting anything.
- An update in place. This must leave the occupancy count unchanged.

// File: rtl/ale_pkg.sv
package ale_pkg;
    localparam int HASH_W    = 8;
    localparam int PORT_W    = 4;
    localparam int PRIO_W    = 3;
    localparam int MACHI_W   = 16;
    localparam int VALID_BIT = 16;
    localparam int TYPE_BIT  = 17;
    localparam int PORT_LSB  = 18;
    localparam int PRIO_LSB  = 22;
    localparam int TIME_LSB  = 22;
    localparam int HASH_LSB  = 16;
    localparam int RPORT_LSB = 24;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_STATIC = 2'd1,
        OP_LEARN  = 2'd2,
        OP_CLEAR  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_READ, S_EVAL, S_WRITE, S_CLEAR, S_DONE
    } state_e;
endpackage

// File: rtl/ale_table_ram.sv
module ale_table_ram #(
    parameter int DEPTH = 2048,
    parameter int DW    = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
        if (we) mem[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/ale_slot_eval.sv
module ale_slot_eval import ale_pkg::*; #(
    parameter int TS_W = 10
) (
    input  logic [63:0]        entry,
    input  logic [31:0]        key_lo,
    input  logic [MACHI_W-1:0] key_hi,
    input  logic [TS_W-1:0]    now,
    output logic               vacant,
    output logic               match,
    output logic               fwd,
    output logic [PORT_W-1:0]  port,
    output logic [TS_W-1:0]    age
);
    logic [31:0] lo_w, hi_w;
    logic        unused_bits;

    assign lo_w   = entry[31:0];
    assign hi_w   = entry[63:32];
    assign vacant = !hi_w[VALID_BIT];
    assign match  = hi_w[VALID_BIT] && (lo_w == key_lo) && (hi_w[MACHI_W-1:0] == key_hi);
    assign fwd    = match && !hi_w[TYPE_BIT];
    assign port   = hi_w[PORT_LSB +: PORT_W];
    assign age    = now - hi_w[TIME_LSB +: TS_W];
    assign unused_bits = ^hi_w;
endmodule

// File: rtl/addr_learn_engine.sv
module addr_learn_engine import ale_pkg::*; #(
    parameter int          ENTRY_CNT = 2048,
    parameter int          TS_W      = 10,
    parameter int          CNT_W     = 16,
    parameter logic [3:0]  FWD_INIT  = 4'hF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [1:0]                  req_op,
    input  logic [31:0]                 req_w0,
    input  logic [31:0]                 req_w1,
    input  logic [2:0]                  req_prio,
    input  logic [TS_W-1:0]             cur_time,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic [3:0]                  rsp_port,
    output logic [$clog2(ENTRY_CNT):0]  occupied,
    output logic [CNT_W-1:0]            overflows
);
    localparam int IDX_W  = $clog2(ENTRY_CNT);
    localparam int SLOT_W = IDX_W - HASH_W;
    localparam int SLOTS  = 1 << SLOT_W;

    state_e               state_q, state_d;
    op_e                  op_q;
    logic [31:0]          lo_q;
    logic [MACHI_W-1:0]   mhi_q;
    logic [HASH_W-1:0]    hash_q;
    logic [PORT_W-1:0]    port_q;
    logic [PRIO_W-1:0]    prio_q;
    logic [TS_W-1:0]      now_q;
    logic [SLOT_W-1:0]    slot_q, best_slot_q, wr_slot_q;
    logic [TS_W-1:0]      best_age_q;
    logic [IDX_W-1:0]     clr_idx_q;
    logic                 fill_q, evict_q, err_q;
    logic [3:0]           port_rsp_q;
    logic [IDX_W:0]       occ_q;
    logic [CNT_W-1:0]     ovf_q;

    logic [IDX_W-1:0]     rd_addr, wr_addr;
    logic [63:0]          rd_data, wr_data;
    logic [31:0]          new_hi;
    logic                 we;
    logic                 ev_vacant, ev_match, ev_fwd;
    logic [PORT_W-1:0]    ev_port;
    logic [TS_W-1:0]      ev_age;
    logic                 is_last, take_this, clr_last;
    logic                 unused_bits;

    assign unused_bits = ^req_w1[31:28];

    ale_table_ram #(.DEPTH(ENTRY_CNT), .DW(64)) u_ram (
        .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data),
        .we(we), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    ale_slot_eval #(.TS_W(TS_W)) u_eval (
        .entry(rd_data), .key_lo(lo_q), .key_hi(mhi_q), .now(now_q),
        .vacant(ev_vacant), .match(ev_match), .fwd(ev_fwd),
        .port(ev_port), .age(ev_age)
    );

    assign is_last   = (slot_q == SLOT_W'(SLOTS - 1));
    assign take_this = (slot_q == '0) || (ev_age > best_age_q);
    assign clr_last  = (clr_idx_q == IDX_W'(ENTRY_CNT - 1));

    // entry image written by insert or learn
    always_comb begin
        new_hi = '0;
        new_hi[MACHI_W-1:0]          = mhi_q;
        new_hi[VALID_BIT]            = 1'b1;
        new_hi[PORT_LSB +: PORT_W]   = port_q;
        if (op_q == OP_STATIC) begin
            new_hi[TYPE_BIT]           = 1'b1;
            new_hi[PRIO_LSB +: PRIO_W] = prio_q;
        end else begin
            new_hi[TIME_LSB +: TS_W]   = now_q;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = (op_e'(req_op) == OP_CLEAR) ? S_CLEAR : S_READ;
            S_READ:  state_d = S_EVAL;
            S_EVAL: begin
                if (ev_vacant || ev_match)
                    state_d = (op_q == OP_LOOKUP) ? S_DONE : S_WRITE;
                else if (is_last)
                    state_d = (op_q == OP_LEARN) ? S_WRITE : S_DONE;
                else
                    state_d = S_READ;
            end
            S_WRITE: state_d = S_DONE;
            S_CLEAR: if (clr_last) state_d = (op_q == OP_CLEAR) ? S_DONE : S_IDLE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_CLEAR;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_LOOKUP; lo_q <= '0; mhi_q <= '0; hash_q <= '0; port_q <= '0;
            prio_q <= '0; now_q <= '0; slot_q <= '0; best_slot_q <= '0; wr_slot_q <= '0;
            best_age_q <= '0; clr_idx_q <= '0; fill_q <= 1'b0; evict_q <= 1'b0;
            err_q <= 1'b0; port_rsp_q <= FWD_INIT; occ_q <= '0; ovf_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    op_q       <= op_e'(req_op);
                    lo_q       <= req_w0;
                    mhi_q      <= req_w1[MACHI_W-1:0];
                    hash_q     <= req_w1[HASH_LSB +: HASH_W];
                    port_q     <= req_w1[RPORT_LSB +: PORT_W];
                    prio_q     <= req_prio;
                    now_q      <= cur_time;
                    slot_q     <= '0;
                    clr_idx_q  <= '0;
                    fill_q     <= 1'b0;
                    evict_q    <= 1'b0;
                    err_q      <= 1'b0;
                    port_rsp_q <= FWD_INIT;
                    if (op_e'(req_op) == OP_CLEAR) occ_q <= '0;
                end
                S_EVAL: begin
                    if (ev_vacant) begin
                        wr_slot_q <= slot_q;
                        fill_q    <= 1'b1;
                    end else if (ev_match) begin
                        wr_slot_q <= slot_q;
                        if (ev_fwd) port_rsp_q <= ev_port;
                    end else begin
                        if (take_this) begin
                            best_age_q  <= ev_age;
                            best_slot_q <= slot_q;
                        end
                        if (is_last) begin
                            wr_slot_q <= take_this ? slot_q : best_slot_q;
                            evict_q   <= (op_q == OP_LEARN);
                            err_q     <= (op_q == OP_STATIC);
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                S_WRITE: begin
                    if (fill_q)  occ_q <= occ_q + 1'b1;
                    if (evict_q) ovf_q <= ovf_q + 1'b1;
                end
                S_CLEAR: clr_idx_q <= clr_idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs and RAM controls
    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_valid = (state_q == S_DONE);
        rsp_err   = err_q;
        rsp_port  = port_rsp_q;
        occupied  = occ_q;
        overflows = ovf_q;
        rd_addr   = {hash_q, slot_q};
        we        = (state_q == S_CLEAR) || (state_q == S_WRITE);
        wr_addr   = (state_q == S_CLEAR) ? clr_idx_q : {hash_q, wr_slot_q};
        wr_data   = (state_q == S_CLEAR) ? 64'd0 : {new_hi, lo_q};
    end
endmodule

// File: rtl/ale_checker.sv
module ale_checker #(
    parameter int ENTRY_CNT = 2048,
    parameter int CNT_W     = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic                        rsp_valid,
    input logic [$clog2(ENTRY_CNT):0]  occupied,
    input logic [CNT_W-1:0]            overflows
);
    localparam int OW = $clog2(ENTRY_CNT) + 1;

    // R10: engine is busy after taking a request
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: response is a single-cycle pulse followed by idle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R7: occupancy moves only by one fill or back to zero on clear
    a_r7_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(occupied) |-> ((occupied == OW'($past(occupied) + 1'b1)) || (occupied == '0)));

    // R7: occupancy never exceeds the table size
    a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occupied <= OW'(ENTRY_CNT));

    // R8: overflow counter advances by one per eviction
    a_r8_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(overflows) |-> (overflows == CNT_W'($past(overflows) + 1'b1)));
endmodule

bind addr_learn_engine ale_checker #(.ENTRY_CNT(ENTRY_CNT), .CNT_W(CNT_W)) u_ale_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .occupied(occupied), .overflows(overflows)
);

// File: tb/addr_learn_engine_bench.sv
module addr_learn_engine_bench;
    localparam int         ENTRIES = 2048;
    localparam int         NSLOT   = 8;
    localparam logic [3:0] INIT    = 4'hF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [31:0] req_w0 = '0, req_w1 = '0;
    logic [2:0]  req_prio = '0;
    logic [9:0]  cur_time = '0;
    logic        rsp_valid, rsp_err;
    logic [3:0]  rsp_port;
    logic [11:0] occupied;
    logic [15:0] overflows;

    always #4 clk = ~clk;

    addr_learn_engine u_addr_learn_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_w0(req_w0), .req_w1(req_w1), .req_prio(req_prio),
        .cur_time(cur_time), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_port(rsp_port), .occupied(occupied), .overflows(overflows)
    );

    int          n_chk = 0, n_bad = 0, cyc = 0;
    int          m_occ = 0, m_ovf = 0;
    bit          pending = 1'b1;
    logic [31:0] m_lo [ENTRIES];
    logic [31:0] m_hi [ENTRIES];

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic [31:0] w1f(input [15:0] mh, input [7:0] h, input [3:0] p);
        return {4'h0, p, h, mh};
    endfunction

    // behavioural table model
    task automatic model_apply(input int op, input [31:0] w0, input [31:0] w1, input [2:0] prio,
                               input [9:0] now, output bit err, output [3:0] port);
        int          base, best, best_age, age, e;
        bit          done;
        logic [31:0] hn;
        base = int'(w1[23:16]) * NSLOT;
        best = base; best_age = -1; done = 0; err = 0; port = INIT;
        if (op == 3) begin
            for (int i = 0; i < ENTRIES; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
            m_occ = 0;
            return;
        end
        hn = 0; hn[15:0] = w1[15:0]; hn[16] = 1; hn[21:18] = w1[27:24];
        if (op == 1) begin hn[17] = 1; hn[24:22] = prio; end
        else hn[31:22] = now;
        for (int s = 0; s < NSLOT; s++) begin
            e = base + s;
            if (!done) begin
                if (!m_hi[e][16]) begin
                    if (op != 0) begin m_lo[e] = w0; m_hi[e] = hn; m_occ++; end
                    done = 1;
                end else if (m_lo[e] == w0 && m_hi[e][15:0] == w1[15:0]) begin
                    if (op == 0) begin
                        if (!m_hi[e][17]) port = m_hi[e][21:18];
                    end else begin
                        m_lo[e] = w0; m_hi[e] = hn;
                    end
                    done = 1;
                end else begin
                    age = int'(10'(now - m_hi[e][31:22]));
                    if (age > best_age) begin best = e; best_age = age; end
                end
            end
        end
        if (!done) begin
            if (op == 2) begin m_lo[best] = w0; m_hi[best] = hn; m_ovf++; end
            else if (op == 1) err = 1;
        end
    endtask

    task automatic do_req(input string tag, input int op, input [31:0] w0, input [31:0] w1,
                          input [2:0] prio, input [9:0] now);
        bit         e_err;
        logic [3:0] e_port;
        pending = 1'b1;
        model_apply(op, w0, w1, prio, now, e_err, e_port);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_w0 = w0; req_w1 = w1;
        req_prio = prio; cur_time = now;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", "ready after accept", req_ready, 0);
        while (!rsp_valid) @(negedge clk);
        if (op != 3) check(tag, "rsp_err", rsp_err, e_err);
        if (op == 0) check(tag, "rsp_port", rsp_port, e_port);
        @(negedge clk);
        check("R10", "single rsp pulse", rsp_valid, 0);
        pending = 1'b0;
    endtask

    // per-clock comparison of counters against the model, plus watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
        if (!pending && rst_n && req_ready) begin
            check("R7", "occupied", occupied, m_occ);
            check("R8", "overflows", overflows, m_ovf);
        end
    end

    localparam logic [31:0] K1 = 32'hA1B2C3D4;
    localparam logic [31:0] K2 = 32'h11223344;

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready low during reset clear", req_ready, 0);
        while (!req_ready) @(negedge clk);
        check("R1", "occupied after reset", occupied, 0);
        check("R1", "rsp_valid after reset", rsp_valid, 0);
        pending = 1'b0;

        // R3 miss on empty table
        do_req("R3", 0, K1, w1f(16'h0506, 8'd5, 0), 0, 0);
        // R2 / R6 learn then lookup
        do_req("R6", 2, K1, w1f(16'h0506, 8'd5, 4'd3), 0, 10'd100);
        do_req("R2", 0, K1, w1f(16'h0506, 8'd5, 0), 0, 0);
        // R4 same low word, different high bits
        do_req("R4", 0, K1, w1f(16'h0507, 8'd5, 0), 0, 0);
        // R6 / R7 update in place
        do_req("R6", 2, K1, w1f(16'h0506, 8'd5, 4'd9), 0, 10'd110);
        do_req("R6", 0, K1, w1f(16'h0506, 8'd5, 0), 0, 0);
        // R5 static entries are not forwarded; static overwrites dynamic
        do_req("R5", 1, K2, w1f(16'h0001, 8'd5, 4'd6), 3'd5, 0);
        do_req("R5", 0, K2, w1f(16'h0001, 8'd5, 0), 0, 0);
        do_req("R5", 1, K1, w1f(16'h0506, 8'd5, 4'd2), 3'd1, 0);
        do_req("R5", 0, K1, w1f(16'h0506, 8'd5, 0), 0, 0);

        // R8 eviction with timestamp wraparound in bucket 9
        do_req("R7", 2, 32'h100, w1f(16'h0, 8'd9, 4'd1), 0, 10'd1020);
        for (int i = 1; i < NSLOT; i++)
            do_req("R7", 2, 32'h100 + i, w1f(16'h0, 8'd9, 4'(i + 1)), 0, 10'd5);
        do_req("R8", 2, 32'h1FF, w1f(16'h0, 8'd9, 4'd12), 0, 10'd8);
        do_req("R8", 0, 32'h100, w1f(16'h0, 8'd9, 0), 0, 0);
        do_req("R8", 0, 32'h1FF, w1f(16'h0, 8'd9, 0), 0, 0);
        do_req("R8", 0, 32'h101, w1f(16'h0, 8'd9, 0), 0, 0);

        // R8 equal ages: lowest slot is replaced
        for (int i = 0; i < NSLOT; i++)
            do_req("R7", 2, 32'h200 + i, w1f(16'h7, 8'd20, 4'(i)), 0, 10'd50);
        do_req("R8", 2, 32'h2FF, w1f(16'h7, 8'd20, 4'd13), 0, 10'd60);
        do_req("R8", 0, 32'h200, w1f(16'h7, 8'd20, 0), 0, 0);
        do_req("R8", 0, 32'h207, w1f(16'h7, 8'd20, 0), 0, 0);

        // R9 static insert into full bucket
        do_req("R9", 1, 32'h3AA, w1f(16'h7, 8'd20, 4'd5), 3'd2, 0);
        do_req("R9", 0, 32'h201, w1f(16'h7, 8'd20, 0), 0, 0);
        do_req("R9", 0, 32'h2FF, w1f(16'h7, 8'd20, 0), 0, 0);
        do_req("R3", 0, 32'h3AA, w1f(16'h7, 8'd20, 0), 0, 0);

        // R1 clear request
        do_req("R1", 3, 0, 0, 0, 0);
        @(negedge clk);
        check("R1", "occupied after clear", occupied, 0);
        do_req("R1", 0, 32'h201, w1f(16'h7, 8'd20, 0), 0, 0);
        do_req("R1", 0, 32'h1FF, w1f(16'h0, 8'd9, 0), 0, 0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule